// File: doc/BRIEF.md
# Dual-Port RAM with Write Bypass

This block is a synchronous RAM with one write port and one read port. Each port has its own address, and both run on one clock. Reads take one cycle: the address presented in one cycle selects the word that appears on the output in the next. The storage array on its own is read-first. If a read and a write hit the same word in the same cycle, the array returns the old contents, and the new value only becomes visible one cycle later.

To give write-first behaviour across the two ports, the array is wrapped in a small bypass stage. A register captures the write data whenever a same-address collision happens with both enables high. A registered select flag records that collision. An output mux then chooses between the captured word and the array output. The select flag and the array output register both load only on enabled reads, so a disabled read leaves the output exactly as it was.

Top module: `dpbyp_ram`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`, and a later enabled read of that address returns it; with `wr_en` low, nothing is stored.
- R2: With `rd_en` high in cycle N, `rd_data` in cycle N+1 equals the word held at `rd_addr` as seen by the read in cycle N.
- R3: When `wr_en` and `rd_en` are both high in one cycle with `wr_addr` equal to `rd_addr`, `rd_data` in the next cycle equals that cycle's `wr_data`, even if the address was never written before.
- R4: Back-to-back collisions on one address each return the data written in their own cycle, and a following enabled read without a write returns the last of them.
- R5: While `rd_en` is low, `rd_data` does not change, whatever the write port does, including writes to the address last read.
- R6: When `wr_addr` differs from `rd_addr`, a concurrent write has no effect on the word returned by the read.
- R7: Reset clears only the bypass selection. Memory contents are kept, and after reset `rd_data` shows the array word from the last enabled read. Memory and output are otherwise undefined after power-up.
- R8: The bypass selection ends at the first enabled read that is not a collision. From then on the output follows the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the bypass selection |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write address, AW = clog2(DEPTH) |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read enable; low holds the output |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data |

## Verification
The main function is driven with four kinds of traffic:
- random traffic confined to four addresses, so collisions, plain reads and writes mix densely;
- a directed table of differing addresses, which shows that a concurrent write cannot disturb an unrelated read;
- repeated same-address collisions, which separate a true forward from a one-cycle-stale array read;
- cycles with the read enable low while writes continue, which expose any capture or select register that updates when it should hold.

A final reset sequence, run after a collision, shows that reset drops the forwarded word and exposes the array output, while the memory itself stays intact.

// File: rtl/dpbyp_pkg.sv
package dpbyp_pkg;

    typedef enum logic {
        SRC_ARRAY  = 1'b0,
        SRC_BYPASS = 1'b1
    } rd_src_e;

    function automatic rd_src_e pick_src(input logic wen, input logic same_addr);
        return (wen && same_addr) ? SRC_BYPASS : SRC_ARRAY;
    endfunction

endpackage

// File: rtl/dpbyp_array.sv
module dpbyp_array #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    logic [DW-1:0] store [DEPTH];

    // read-first: the read register takes the contents before this edge's write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= store[rd_addr];
        end
    end
endmodule

// File: rtl/dpbyp_capture.sv
module dpbyp_capture
    import dpbyp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output rd_src_e       src_q,
    output logic [DW-1:0] cap_q
);
    logic same_addr;
    assign same_addr = (wr_addr == rd_addr);

    // the select flag loads only on enabled reads, so a held output stays put
    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_ARRAY;
        end else if (rd_en) begin
            src_q <= pick_src(wr_en, same_addr);
        end
    end

    // the captured word changes only on a collision, never while the output is held
    always_ff @(posedge clk) begin
        if (rd_en && wr_en && same_addr) begin
            cap_q <= wr_data;
        end
    end
endmodule

// File: rtl/dpbyp_ram.sv
module dpbyp_ram
    import dpbyp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } rd_req_t;

    wr_req_t       wreq;
    rd_req_t       rreq;
    logic [DW-1:0] arr_q;
    logic [DW-1:0] cap_q;
    rd_src_e       src_q;

    assign wreq = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign rreq = '{en: rd_en, addr: rd_addr};

    dpbyp_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .wr_en   (wreq.en),
        .wr_addr (wreq.addr),
        .wr_data (wreq.data),
        .rd_en   (rreq.en),
        .rd_addr (rreq.addr),
        .rd_q    (arr_q)
    );

    dpbyp_capture #(.DW(DW), .AW(AW)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wreq.en),
        .wr_addr (wreq.addr),
        .wr_data (wreq.data),
        .rd_en   (rreq.en),
        .rd_addr (rreq.addr),
        .src_q   (src_q),
        .cap_q   (cap_q)
    );

    always_comb begin
        unique case (src_q)
            SRC_BYPASS: rd_data = cap_q;
            default:    rd_data = arr_q;
        endcase
    end
endmodule

// File: rtl/dpbyp_chk.sv
module dpbyp_chk
    import dpbyp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] arr_q,
    input rd_src_e       src_q
);
    AST_COLLIDE_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && wr_addr == rd_addr) |=> rd_data == $past(wr_data)); // R3

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R5

    AST_PLAIN_READ_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && wr_addr == rd_addr)) |=> rd_data == arr_q); // R6

    AST_BYPASS_DROPS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && wr_addr == rd_addr)) |=> src_q == SRC_ARRAY); // R8

    AST_RESET_SELECT: assert property (@(posedge clk)
        rst |=> src_q == SRC_ARRAY); // R7
endmodule

bind dpbyp_ram dpbyp_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .arr_q   (arr_q),
    .src_q   (src_q)
);

// File: tb/tb_dpbyp_ram.sv
module tb_dpbyp_ram;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int NVEC  = 13;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic          re;
        logic [AW-1:0] ra;
        logic          chk;
        logic [DW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 5'd3, 16'h1111, 1'b0, 5'd0, 1'b0, 16'h0000, 4'd1},
        '{1'b1, 5'd4, 16'h2222, 1'b1, 5'd3, 1'b1, 16'h1111, 4'd6},
        '{1'b1, 5'd3, 16'hAAAA, 1'b1, 5'd3, 1'b1, 16'hAAAA, 4'd3},
        '{1'b1, 5'd3, 16'hBBBB, 1'b1, 5'd3, 1'b1, 16'hBBBB, 4'd4},
        '{1'b0, 5'd3, 16'h0000, 1'b1, 5'd3, 1'b1, 16'hBBBB, 4'd4},
        '{1'b1, 5'd3, 16'hCCCC, 1'b0, 5'd3, 1'b1, 16'hBBBB, 4'd5},
        '{1'b1, 5'd4, 16'h3333, 1'b1, 5'd4, 1'b1, 16'h3333, 4'd3},
        '{1'b1, 5'd4, 16'h4444, 1'b0, 5'd4, 1'b1, 16'h3333, 4'd5},
        '{1'b0, 5'd0, 16'h0000, 1'b1, 5'd4, 1'b1, 16'h4444, 4'd2},
        '{1'b1, 5'd3, 16'h5555, 1'b1, 5'd4, 1'b1, 16'h4444, 4'd8},
        '{1'b0, 5'd0, 16'h0000, 1'b1, 5'd3, 1'b1, 16'h5555, 4'd1},
        '{1'b1, 5'd7, 16'h7777, 1'b1, 5'd7, 1'b1, 16'h7777, 4'd3},
        '{1'b1, 5'd7, 16'h0F0F, 1'b0, 5'd7, 1'b1, 16'h7777, 4'd5}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_mem [DEPTH];
    bit            m_vld [DEPTH];
    logic [DW-1:0] m_out;
    bit            m_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpbyp_ram #(.DW(DW), .DEPTH(DEPTH)) dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle from a negedge, update the reference at the edge, return at next negedge
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                        input logic re, input logic [AW-1:0] ra);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        if (re) begin
            if (we && wa == ra) begin
                m_out = wd; m_ok = 1'b1;
            end else begin
                m_out = m_mem[ra]; m_ok = m_vld[ra];
            end
        end
        if (we) begin
            m_mem[wa] = wd; m_vld[wa] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
        m_ok = 1'b0;
        m_out = '0;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // directed table walk: R1 R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NVEC; v++) begin
            step(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].re, VECS[v].ra);
            if (VECS[v].chk) check($sformatf("R%0d vec%0d", VECS[v].req, v), rd_data, VECS[v].exp);
        end

        // random traffic on few addresses to force collisions: R2 R3 R5 R6
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] wa_r, ra_r;
            wa_r = AW'($urandom_range(0, 3));
            ra_r = AW'($urandom_range(0, 3));
            step(($urandom_range(0, 3) != 0), wa_r, DW'($urandom),
                 ($urandom_range(0, 3) != 0), ra_r);
            if (m_ok) check("R2 random", rd_data, m_out);
        end

        // reset keeps memory and drops the bypass: R7
        step(1'b1, 5'd9, 16'h9999, 1'b0, 5'd0);
        step(1'b0, 5'd0, 16'h0000, 1'b1, 5'd9);
        check("R1 reset-prep", rd_data, 16'h9999);
        step(1'b1, 5'd9, 16'hABCD, 1'b1, 5'd9);
        check("R3 reset-prep", rd_data, 16'hABCD);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R7 after reset", rd_data, 16'h9999);
        step(1'b0, 5'd0, 16'h0000, 1'b1, 5'd9);
        check("R7 memory kept", rd_data, 16'hABCD);

        // write disabled stores nothing: R1
        step(1'b0, 5'd9, 16'h1234, 1'b0, 5'd9);
        step(1'b0, 5'd0, 16'h0000, 1'b1, 5'd9);
        check("R1 no write", rd_data, 16'hABCD);

        finish_run();
    end
endmodule